// File: doc/BRIEF.md
# Sequencer Control Register and Memory Port

This block is the host-facing register front end of a timing sequencer. A simple synchronous bus (word offset, write strobe, read strobe, 16-bit write data, 16-bit registered read data) reaches three locations. The first is a combined status/control word. The second is a 10-bit sequencer memory pointer. The third is a data window into a 1024 x 16 sequencer memory held inside the block.

The control half of the status/control word is twelve configuration bits. They drive the rest of the module through `cfg_out`, and three of them steer the data window: a lock for each byte lane, and post-increment of the pointer on writes and on reads. The status half reports a live pod-present level and two sticky event flags, end-of-sequence and breakpoint. A hard reset (asynchronous), a soft reset (synchronous) or an INIT pulse clears the sticky flags. The resets also clear the configuration bits and the pointer.

Top module: `seq_ctl_regfile`

## Requirements
- R1: A read at offset 06h returns {bit15 = 0, bit14 = pod-present, bit13 = end-of-sequence flag, bit12 = breakpoint flag, bits 11:0 = configuration}. A write there leaves bits 15:12 of later reads unaffected.
- R2: Bit 14 of an offset 06h read reflects `pod_present` in the cycle the read strobe is sampled. It is not stored.
- R3: Bits 11:0 at offset 06h read back the last value written and are driven continuously on `cfg_out`. A hard reset (`rst_n` low) or a soft reset (`soft_rst` high for one cycle) sets them to 0.
- R4: `eos_evt` / `brk_evt` pulses set bit 13 / bit 12. Each flag stays set until a hard reset, a soft reset or `init_cmd` clears it. An event in the same cycle as a clear leaves the flag set.
- R5: Offset 10h holds the 10-bit memory pointer. A write loads it from write-data bits 9:0, a read returns it zero-extended, and both resets set it to 0.
- R6: A write at offset 12h stores the write data at the current pointer. With configuration bit 3 set, bits 15:8 of that word are kept. With bit 2 set, bits 7:0 are kept.
- R7: With configuration bit 4 set, each write at offset 12h advances the pointer by one, wrapping from 3FFh to 0. With bit 4 clear, the pointer is left unchanged.
- R8: With configuration bit 5 set, each read at offset 12h advances the pointer by one after the access. The data returned is the word at the pointer value before the advance. With bit 5 clear, the pointer is left unchanged.
- R9: Read data appears on `bus_rdata` one clock after the read strobe is sampled and holds until the next read. Unmapped offsets read as 0.
- R10: A cycle with both strobes high is treated as a write only. `bus_rdata` is left unchanged and the pointer advances at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| init_cmd | input | 1 | INIT pulse; clears the sticky event flags |
| bus_addr | input | 8 | Word offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pod_present | input | 1 | Pod attached level |
| eos_evt | input | 1 | End-of-sequence event pulse |
| brk_evt | input | 1 | Breakpoint event pulse |
| cfg_out | output | 12 | Configuration bits 11:0 |

## Verification
Each register update (configuration, sticky flag, pointer, memory word) takes effect at the first clock edge after its strobe or event. It becomes visible through a read whose data is due one edge after that read strobe. The bench drives every strobe and event on the falling edge for exactly one cycle. It then samples `bus_rdata` and `cfg_out` on the next falling edge, after the single registering edge. Pointer movement and byte locks are observed only through later reads at 10h and 12h.

// File: rtl/seq_ctl_pkg.sv
package seq_ctl_pkg;
  localparam int DATA_W     = 16;
  localparam int CFG_W      = 12;
  localparam int LANE_W     = 8;
  localparam int SEQ_AW_DEF = 10;
  localparam int BUS_AW_DEF = 8;

  localparam int OFF_CSR    = 'h06;
  localparam int OFF_PTR    = 'h10;
  localparam int OFF_DATA   = 'h12;

  // configuration bit positions that this block decodes itself
  localparam int CFG_LO_LOCK = 2;
  localparam int CFG_HI_LOCK = 3;
  localparam int CFG_INC_WR  = 4;
  localparam int CFG_INC_RD  = 5;

  // status bit positions in the status/control word
  localparam int ST_BRK  = 12;
  localparam int ST_EOS  = 13;
  localparam int ST_POD  = 14;
endpackage

// File: rtl/seq_ctl_cfg_reg.sv
module seq_ctl_cfg_reg
  import seq_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             init_cmd,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  input  logic             eos_evt,
  input  logic             brk_evt,
  output logic [CFG_W-1:0] cfg_q,
  output logic             eos_q,
  output logic             brk_q
);
  logic [CFG_W-1:0] cfg_d;
  logic             eos_d;
  logic             brk_d;
  logic             flag_clr;

  assign flag_clr = soft_rst | init_cmd;

  always_comb begin
    cfg_d = cfg_q;
    if (soft_rst)   cfg_d = '0;
    else if (wr_en) cfg_d = wdata;
  end

  // event input takes precedence over a clear in the same cycle
  always_comb begin
    eos_d = (eos_q & ~flag_clr) | eos_evt;
    brk_d = (brk_q & ~flag_clr) | brk_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      eos_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      eos_q <= eos_d;
      brk_q <= brk_d;
    end
  end
endmodule

// File: rtl/seq_ctl_ptr.sv
module seq_ctl_ptr #(
  parameter int SEQ_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              load,
  input  logic [SEQ_AW-1:0] load_val,
  input  logic              inc,
  output logic [SEQ_AW-1:0] ptr_q
);
  logic [SEQ_AW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (soft_rst)  ptr_d = '0;
    else if (load) ptr_d = load_val;
    else if (inc)  ptr_d = ptr_q + SEQ_AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/seq_ctl_mem.sv
module seq_ctl_mem
  import seq_ctl_pkg::*;
#(
  parameter int SEQ_AW = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SEQ_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W/LANE_W-1:0] lane_lock,
  output logic [DATA_W-1:0] rword
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int DEPTH = 1 << SEQ_AW;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic              lane_we;

    assign lane_we = we & ~lane_lock[ln];

    always_ff @(posedge clk) begin
      if (lane_we) lane_mem[addr] <= wdata[ln*LANE_W +: LANE_W];
    end

    assign rword[ln*LANE_W +: LANE_W] = lane_mem[addr];
  end
endmodule

// File: rtl/seq_ctl_regfile.sv
module seq_ctl_regfile
  import seq_ctl_pkg::*;
#(
  parameter int SEQ_AW = SEQ_AW_DEF,
  parameter int BUS_AW = BUS_AW_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              init_cmd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pod_present,
  input  logic              eos_evt,
  input  logic              brk_evt,
  output logic [CFG_W-1:0]  cfg_out
);
  localparam int LANES  = DATA_W / LANE_W;
  localparam int PAD_W  = DATA_W - SEQ_AW;

  logic              sel_csr, sel_ptr, sel_data;
  logic              wr_op, rd_op;
  logic [CFG_W-1:0]  cfg_q;
  logic              eos_q, brk_q;
  logic [SEQ_AW-1:0] seq_addr;
  logic              ptr_inc;
  logic [DATA_W-1:0] mem_word;
  logic [LANES-1:0]  lane_lock;
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  assign sel_csr  = (bus_addr == BUS_AW'(OFF_CSR));
  assign sel_ptr  = (bus_addr == BUS_AW'(OFF_PTR));
  assign sel_data = (bus_addr == BUS_AW'(OFF_DATA));
  assign wr_op    = bus_wr;
  assign rd_op    = bus_rd & ~bus_wr;

  assign ptr_inc = sel_data & ((wr_op & cfg_q[CFG_INC_WR]) |
                               (rd_op & cfg_q[CFG_INC_RD]));

  assign lane_lock = {cfg_q[CFG_HI_LOCK], cfg_q[CFG_LO_LOCK]};

  seq_ctl_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .init_cmd (init_cmd),
    .wr_en    (wr_op & sel_csr),
    .wdata    (bus_wdata[CFG_W-1:0]),
    .eos_evt  (eos_evt),
    .brk_evt  (brk_evt),
    .cfg_q    (cfg_q),
    .eos_q    (eos_q),
    .brk_q    (brk_q)
  );

  seq_ctl_ptr #(.SEQ_AW(SEQ_AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .load     (wr_op & sel_ptr),
    .load_val (bus_wdata[SEQ_AW-1:0]),
    .inc      (ptr_inc),
    .ptr_q    (seq_addr)
  );

  seq_ctl_mem #(.SEQ_AW(SEQ_AW)) u_mem (
    .clk       (clk),
    .we        (wr_op & sel_data),
    .addr      (seq_addr),
    .wdata     (bus_wdata),
    .lane_lock (lane_lock),
    .rword     (mem_word)
  );

  always_comb begin
    status_word              = '0;
    status_word[CFG_W-1:0]   = cfg_q;
    status_word[ST_BRK]      = brk_q;
    status_word[ST_EOS]      = eos_q;
    status_word[ST_POD]      = pod_present;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_op) begin
      if (sel_csr)       rdata_d = status_word;
      else if (sel_ptr)  rdata_d = {{PAD_W{1'b0}}, seq_addr};
      else if (sel_data) rdata_d = mem_word;
      else               rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign cfg_out   = cfg_q;
endmodule

// File: rtl/seq_ctl_regfile_chk.sv
module seq_ctl_regfile_chk
  import seq_ctl_pkg::*;
#(
  parameter int SEQ_AW = 10,
  parameter int BUS_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              init_cmd,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              eos_evt,
  input logic [CFG_W-1:0]  cfg_out,
  input logic              eos_q,
  input logic [SEQ_AW-1:0] seq_addr
);
  logic csr_rd;
  logic data_wr_inc;
  assign csr_rd      = bus_rd && !bus_wr && (bus_addr == BUS_AW'(OFF_CSR));
  assign data_wr_inc = bus_wr && (bus_addr == BUS_AW'(OFF_DATA)) && cfg_out[CFG_INC_WR];

  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd |=> (bus_rdata[DATA_W-1] == 1'b0)); // R1

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !(bus_wr && bus_addr == BUS_AW'(OFF_CSR))) |=> $stable(cfg_out)); // R3

  AST_EOS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    eos_evt |=> eos_q); // R4

  AST_EOS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (init_cmd && !eos_evt) |=> !eos_q); // R4

  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !bus_rd && !soft_rst) |=> $stable(seq_addr)); // R5

  AST_PTR_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_inc && !soft_rst) |=> (seq_addr == SEQ_AW'($past(seq_addr) + SEQ_AW'(1)))); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || !bus_rd) |=> $stable(bus_rdata)); // R10
endmodule

bind seq_ctl_regfile seq_ctl_regfile_chk #(.SEQ_AW(SEQ_AW), .BUS_AW(BUS_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_rst  (soft_rst),
  .init_cmd  (init_cmd),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .eos_evt   (eos_evt),
  .cfg_out   (cfg_out),
  .eos_q     (eos_q),
  .seq_addr  (seq_addr)
);

// File: tb/test_seq_ctl_regfile.sv
module test_seq_ctl_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_rst;
  logic        init_cmd;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        pod_present;
  logic        eos_evt;
  logic        brk_evt;
  logic [11:0] cfg_out;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  seq_ctl_regfile i_seq_ctl_regfile (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .init_cmd(init_cmd),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pod_present(pod_present), .eos_evt(eos_evt), .brk_evt(brk_evt),
    .cfg_out(cfg_out)
  );

  // {op(1 = write, 0 = read and compare), offset, write data / expected}
  localparam logic [24:0] VEC [0:23] = '{
    {1'b1, 8'h06, 16'hFFFF},  // R3 all config bits
    {1'b0, 8'h06, 16'h4FFF},  // R1 R2 R3
    {1'b1, 8'h06, 16'h0000},
    {1'b0, 8'h06, 16'h4000},  // R3
    {1'b1, 8'h10, 16'hFFFE},  // R5 only bits 9:0 load
    {1'b0, 8'h10, 16'h03FE},  // R5
    {1'b1, 8'h06, 16'h0010},  // inc on write
    {1'b1, 8'h12, 16'hA1B2},  // R6 R7
    {1'b1, 8'h12, 16'hC3D4},
    {1'b0, 8'h10, 16'h0000},  // R7 wrap
    {1'b1, 8'h06, 16'h0020},  // inc on read
    {1'b1, 8'h10, 16'h03FE},
    {1'b0, 8'h12, 16'hA1B2},  // R8 pre-increment word
    {1'b0, 8'h12, 16'hC3D4},  // R8
    {1'b0, 8'h10, 16'h0000},  // R8 wrap
    {1'b1, 8'h06, 16'h0008},  // high lane locked
    {1'b1, 8'h10, 16'h03FE},
    {1'b1, 8'h12, 16'hFFFF},  // R6
    {1'b1, 8'h06, 16'h0004},  // low lane locked
    {1'b1, 8'h12, 16'h0000},  // R6
    {1'b1, 8'h06, 16'h0000},
    {1'b0, 8'h12, 16'h00FF},  // R6
    {1'b0, 8'h10, 16'h03FE},  // R8 no step with bit 5 clear
    {1'b0, 8'h20, 16'h0000}   // R9 unmapped
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] q);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    q = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] q;
    rst_n = 1'b0; soft_rst = 1'b0; init_cmd = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    pod_present = 1'b0; eos_evt = 1'b0; brk_evt = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 reset cfg_out", {4'h0, cfg_out}, 16'h0000);
    check("R9 reset rdata", bus_rdata, 16'h0000);
    rst_n = 1'b1;
    bus_read(8'h06, q); check("R2 pod absent", q, 16'h0000);
    bus_read(8'h10, q); check("R5 reset pointer", q, 16'h0000);
    pod_present = 1'b1;

    for (int i = 0; i < 24; i++) begin
      if (VEC[i][24]) bus_write(VEC[i][23:16], VEC[i][15:0]);
      else begin
        bus_read(VEC[i][23:16], q);
        check($sformatf("R1-table entry %0d", i), q, VEC[i][15:0]);
      end
    end

    // sticky flags R4
    @(negedge clk); eos_evt = 1'b1;
    @(negedge clk); eos_evt = 1'b0;
    repeat (3) @(negedge clk);
    bus_read(8'h06, q); check("R4 eos sticky", q, 16'h6000);
    @(negedge clk); brk_evt = 1'b1;
    @(negedge clk); brk_evt = 1'b0;
    bus_read(8'h06, q); check("R4 both flags", q, 16'h7000);
    bus_write(8'h06, 16'h8000);  // R1 writes to the status bits ignored
    bus_read(8'h06, q); check("R1 status bits not writable", q, 16'h7000);
    @(negedge clk); init_cmd = 1'b1;
    @(negedge clk); init_cmd = 1'b0;
    bus_read(8'h06, q); check("R4 init clears", q, 16'h4000);
    @(negedge clk); init_cmd = 1'b1; brk_evt = 1'b1;
    @(negedge clk); init_cmd = 1'b0; brk_evt = 1'b0;
    bus_read(8'h06, q); check("R4 event beats init", q, 16'h5000);
    pod_present = 1'b0;
    bus_read(8'h06, q); check("R2 pod live", q, 16'h1000);
    pod_present = 1'b1;

    // soft reset R3 R5
    bus_write(8'h06, 16'h0ABC);
    bus_write(8'h10, 16'h0055);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check("R3 soft reset cfg_out", {4'h0, cfg_out}, 16'h0000);
    bus_read(8'h06, q); check("R4 soft reset flags", q, 16'h4000);
    bus_read(8'h10, q); check("R5 soft reset pointer", q, 16'h0000);

    // both strobes R10, hold R9
    bus_write(8'h06, 16'h0030);
    bus_write(8'h10, 16'h0100);
    bus_read(8'h06, q);
    repeat (2) @(negedge clk);
    check("R9 rdata holds", bus_rdata, 16'h4030);
    @(negedge clk);
    bus_addr = 8'h12; bus_wdata = 16'h1234; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R10 rdata unchanged", bus_rdata, 16'h4030);
    bus_read(8'h10, q); check("R10 single step", q, 16'h0101);
    bus_write(8'h10, 16'h0100);
    bus_read(8'h12, q); check("R10 write took effect", q, 16'h1234);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule